// File: doc/BRIEF.md
# Gated Two-Stage Clock Divider with Control Register

This block takes one parent clock and derives two slower clocks from it: a card-interface clock and a companion high-speed clock. A single control register sets the ratio. The ratio is the product of two coded stages: a power-of-two prescale, followed by a final divide of 2 or 4. The high-speed clock runs at twice the prescaled period. The card clock runs at the full product ratio. Both outputs have a 50% duty cycle and are phase-aligned, so every card-clock period starts on a high-speed-clock period start.

Software writes the register through a simple single-cycle write strobe and reads it back at any time. Codes that select a ratio outside the supported set are refused. When a code is refused, the register and the running ratio stay as they were, and a sticky error flag rises. Two stop bits gate the two outputs independently. A new ratio and any change of a stop bit take effect only at the end of a complete period of the affected clock. Because of this, an output never produces a runt pulse. A stopped output is held low.

Top module: `sdclk_divider`

## Requirements
- R1: After reset the register reads 0x300 (both stop bits set, both ratio codes zero), both clock outputs are low and the error flag is low.
- R2: The register holds the high-speed stop bit at bit 9, the card stop bit at bit 8, the prescale code at bits 4:2 and the final-divide code at bits 1:0. Readback returns exactly these stored fields, and every other bit reads as zero.
- R3: With prescale code p (0 to 4) and final code f (0 to 1), the card clock has a period of 2^p * 2^(f+1) parent cycles (2, 4, 8, 16, 32 or 64), high for half of it and low for the other half.
- R4: The high-speed clock has a period of 2 * 2^p parent cycles with a 50% duty cycle.
- R5: A write with a prescale code above 4 or a final code above 1 is refused as a whole. Readback and both output periods are unchanged afterwards.
- R6: A refused write sets the error flag one cycle later. The flag stays set until reset, including across later valid writes.
- R7: A new ratio is adopted only when a card-clock period ends. Every high or low pulse on the card clock across the change lasts either the old half period or the new half period.
- R8: Setting bit 9 holds the high-speed clock low after its current period ends, while the card clock keeps running.
- R9: Setting bit 8 holds the card clock low after its current period ends, while the high-speed clock keeps running.
- R10: A stop decision changes only while the gated output is low. Setting both stop bits holds both outputs low and leaves the ratio fields unchanged in readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe, one parent cycle |
| wr_data_i | input | 32 | Register write value |
| rd_data_o | output | 32 | Register readback |
| err_o | output | 1 | Sticky flag for refused ratio codes |
| hs_clk_o | output | 1 | Gated high-speed clock |
| card_clk_o | output | 1 | Gated card clock |

## Verification
Readback is due in the cycle after the write edge, and the error flag rises one cycle after a refused write. A new ratio appears only after the running card period ends, plus one output register. A stop or start appears after the two synchroniser stages, then up to one full period, then the output register, which adds up to at most about 70 parent cycles. For this reason the driver waits 200 cycles after every write before it hands an expected period pair to the monitor. The monitor then measures a whole high phase and a whole low phase, starting from a rising edge. Only the ratio-change test samples during the transition itself. It checks the length of every pulse against the old and new half periods rather than against a fixed cycle.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  localparam int PC_W   = 3;
  localparam int FC_W   = 2;
  localparam int PC_MAX = 4;
  localparam int FC_MAX = 1;
  localparam int CNT_W  = PC_MAX + FC_MAX + 1;
  localparam int RAT_W  = CNT_W + 1;

  localparam int HS_STOP_BIT   = 9;
  localparam int CARD_STOP_BIT = 8;
  localparam int PC_LSB        = 2;
  localparam int FC_LSB        = 0;

  function automatic logic code_ok(logic [PC_W-1:0] pc, logic [FC_W-1:0] fc);
    return (int'(pc) <= PC_MAX) && (int'(fc) <= FC_MAX);
  endfunction

  function automatic logic [RAT_W-1:0] card_ratio(logic [PC_W-1:0] pc,
                                                  logic [FC_W-1:0] fc);
    return RAT_W'(1) << (int'(pc) + int'(fc) + 1);
  endfunction

  function automatic logic [RAT_W-1:0] hs_ratio(logic [PC_W-1:0] pc);
    return RAT_W'(2) << int'(pc);
  endfunction

endpackage

// File: rtl/sdclk_ctrl_reg.sv
module sdclk_ctrl_reg
  import sdclk_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  output logic            hs_stop,
  output logic            card_stop,
  output logic [PC_W-1:0] pc,
  output logic [FC_W-1:0] fc,
  output logic            err
);

  logic [PC_W-1:0] wr_pc;
  logic [FC_W-1:0] wr_fc;
  logic            wr_accept;
  logic            wr_reject;
  logic            unused_wr;

  assign wr_pc     = wr_data[PC_LSB +: PC_W];
  assign wr_fc     = wr_data[FC_LSB +: FC_W];
  assign wr_accept = wr_en && code_ok(wr_pc, wr_fc);
  assign wr_reject = wr_en && !code_ok(wr_pc, wr_fc);
  assign unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_stop   <= 1'b1;
      card_stop <= 1'b1;
      pc        <= '0;
      fc        <= '0;
    end else if (wr_accept) begin
      hs_stop   <= wr_data[HS_STOP_BIT];
      card_stop <= wr_data[CARD_STOP_BIT];
      pc        <= wr_pc;
      fc        <= wr_fc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         err <= 1'b0;
    else if (wr_reject) err <= 1'b1;
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[HS_STOP_BIT]     = hs_stop;
    rd_data[CARD_STOP_BIT]   = card_stop;
    rd_data[PC_LSB +: PC_W]  = pc;
    rd_data[FC_LSB +: FC_W]  = fc;
  end

  // R5: refused write leaves every stored field as it was
  a_r5_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable({hs_stop, card_stop, pc, fc}));

  // R6: refused write raises the flag on the next cycle
  a_r6_err_rise: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> err);

  // R6: flag never falls outside reset
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R5: stored codes always lie in the supported set
  a_r5_codes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pc) <= PC_MAX) && (int'(fc) <= FC_MAX));

endmodule

// File: rtl/sdclk_phase_gen.sv
module sdclk_phase_gen
  import sdclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] new_pc,
  input  logic [FC_W-1:0] new_fc,
  output logic            card_raw,
  output logic            hs_raw,
  output logic            card_end,
  output logic            hs_end
);

  logic [PC_W-1:0]  act_pc;
  logic [FC_W-1:0]  act_fc;
  logic [CNT_W-1:0] phase;
  logic [RAT_W-1:0] n_card;
  logic [RAT_W-1:0] n_hs;
  logic [RAT_W-1:0] ph_ext;
  logic [RAT_W-1:0] hs_mask;
  logic [RAT_W-1:0] hs_pos;

  assign n_card   = card_ratio(act_pc, act_fc);
  assign n_hs     = hs_ratio(act_pc);
  assign ph_ext   = {1'b0, phase};
  assign hs_mask  = n_hs - RAT_W'(1);
  assign hs_pos   = ph_ext & hs_mask;
  assign card_end = (ph_ext == n_card - RAT_W'(1));
  assign hs_end   = (hs_pos == hs_mask);
  assign card_raw = (ph_ext < (n_card >> 1));
  assign hs_raw   = (hs_pos < (n_hs >> 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      act_pc <= '0;
      act_fc <= '0;
    end else if (card_end) begin
      phase  <= '0;
      act_pc <= new_pc;
      act_fc <= new_fc;
    end else begin
      phase  <= phase + CNT_W'(1);
    end
  end

  // R7: running ratio moves only on a card-period boundary
  a_r7_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !card_end |=> ($stable(act_pc) && $stable(act_fc)));

  // R3: phase counter stays inside the running card period
  a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ph_ext < n_card);

  // R4: every card boundary is also a high-speed boundary
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    card_end |-> hs_end);

endmodule

// File: rtl/sdclk_gate.sv
module sdclk_gate #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop,
  input  logic raw,
  input  logic boundary,
  output logic clk_out
);

  logic stop_s;
  logic run_q;

  generate
    if (STAGES == 0) begin : g_nosync
      assign stop_s = stop;
    end else if (STAGES == 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= 1'b1;
        else        s_q <= stop;
      end
      assign stop_s = s_q;
    end else begin : g_syncn
      logic [STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= {s_q[STAGES-2:0], stop};
      end
      assign stop_s = s_q[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= 1'b0;
    else if (boundary) run_q <= !stop_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_out <= 1'b0;
    else        clk_out <= raw & run_q;
  end

  // R10: the run decision flips only while the output is low
  a_r10_flip_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(run_q) |-> !clk_out);

  // R8: a stopped gate produces no high level next cycle
  a_r8_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !clk_out);

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          err_o,
  output logic          hs_clk_o,
  output logic          card_clk_o
);

  logic            hs_stop;
  logic            card_stop;
  logic [PC_W-1:0] cfg_pc;
  logic [FC_W-1:0] cfg_fc;
  logic            card_raw;
  logic            hs_raw;
  logic            card_end;
  logic            hs_end;

  sdclk_ctrl_reg #(.DW(DW)) u_reg (
    .clk       (clk_i),
    .rst_n     (rst_ni),
    .wr_en     (wr_en_i),
    .wr_data   (wr_data_i),
    .rd_data   (rd_data_o),
    .hs_stop   (hs_stop),
    .card_stop (card_stop),
    .pc        (cfg_pc),
    .fc        (cfg_fc),
    .err       (err_o)
  );

  sdclk_phase_gen u_phase (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .new_pc   (cfg_pc),
    .new_fc   (cfg_fc),
    .card_raw (card_raw),
    .hs_raw   (hs_raw),
    .card_end (card_end),
    .hs_end   (hs_end)
  );

  sdclk_gate #(.STAGES(SYNC_STAGES)) u_hs_gate (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .stop     (hs_stop),
    .raw      (hs_raw),
    .boundary (hs_end),
    .clk_out  (hs_clk_o)
  );

  sdclk_gate #(.STAGES(SYNC_STAGES)) u_card_gate (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .stop     (card_stop),
    .raw      (card_raw),
    .boundary (card_end),
    .clk_out  (card_clk_o)
  );

  // R2: bits outside the defined fields always read zero
  a_r2_read_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~DW'(32'h0000_031F)) == '0);

endmodule

// File: tb/sim_sdclk_divider.sv
`timescale 1ns/1ps
module sim_sdclk_divider;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        err;
  logic        hs_clk;
  logic        card_clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit busy     = 1'b0;

  typedef struct {
    int    card_per;
    int    hs_per;
    string req;
  } exp_t;

  exp_t sb_q[$];

  always #2 clk = ~clk;

  sdclk_divider u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_en_i    (wr_en),
    .wr_data_i  (wr_data),
    .rd_data_o  (rd_data),
    .err_o      (err),
    .hs_clk_o   (hs_clk),
    .card_clk_o (card_clk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pick(input bit sel);
    return sel ? hs_clk : card_clk;
  endfunction

  task automatic measure(input bit sel, output int hi, output int lo);
    int guard = 0;
    hi = 0;
    lo = 0;
    while (pick(sel) && guard < 300)  begin @(negedge clk); guard++; end
    while (!pick(sel) && guard < 300) begin @(negedge clk); guard++; end
    while (pick(sel) && guard < 300)  begin @(negedge clk); hi++; guard++; end
    while (!pick(sel) && guard < 300) begin @(negedge clk); lo++; guard++; end
  endtask

  task automatic reg_write(input logic [31:0] val);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = val;
    @(negedge clk);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  task automatic expect_periods(input int card_per, input int hs_per, input string req);
    exp_t e;
    repeat (200) @(negedge clk);
    e.card_per = card_per;
    e.hs_per   = hs_per;
    e.req      = req;
    sb_q.push_back(e);
    @(negedge clk);
    while (sb_q.size() > 0 || busy) @(negedge clk);
  endtask

  // monitor: pops expected periods and measures the outputs
  initial begin
    exp_t e;
    int hi;
    int lo;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        busy = 1'b1;
        e = sb_q.pop_front();
        measure(1'b0, hi, lo);
        chk(hi + lo == e.card_per, {e.req, " card period"}, hi + lo, e.card_per);
        chk(hi == e.card_per / 2, {e.req, " card high time"}, hi, e.card_per / 2);
        measure(1'b1, hi, lo);
        chk(hi + lo == e.hs_per, {e.req, " hs period"}, hi + lo, e.hs_per);
        chk(hi == e.hs_per / 2, {e.req, " hs high time"}, hi, e.hs_per / 2);
        busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int run_len;
    bit prev;
    bit first;
    bit seen_hi;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(rd_data == 32'h300, "R1 readback", int'(rd_data), 32'h300);
    chk(err == 1'b0, "R1 err", int'(err), 0);
    seen_hi = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (hs_clk || card_clk) seen_hi = 1'b1;
    end
    chk(!seen_hi, "R1 outputs low", int'(seen_hi), 0);

    // R3 R4: several ratios
    reg_write(32'h000);
    expect_periods(2, 2, "R3 R4 p0f0");
    reg_write(32'h005);
    expect_periods(8, 4, "R3 R4 p1f1");
    reg_write(32'h00C);
    expect_periods(16, 16, "R3 R4 p3f0");
    reg_write(32'h011);
    expect_periods(64, 32, "R3 R4 p4f1");
    reg_write(32'h00D);
    expect_periods(32, 16, "R3 R4 p3f1");

    // R5 R6: refused prescale code
    reg_write(32'h015);
    chk(rd_data == 32'h00D, "R5 readback after bad prescale", int'(rd_data), 32'h00D);
    chk(err == 1'b1, "R6 err after bad prescale", int'(err), 1);
    expect_periods(32, 16, "R5 ratio kept");

    // R5: refused final code
    reg_write(32'h002);
    chk(rd_data == 32'h00D, "R5 readback after bad final code", int'(rd_data), 32'h00D);

    // R8: high-speed stop only
    reg_write(32'h205);
    chk(rd_data == 32'h205, "R2 readback hs stop", int'(rd_data), 32'h205);
    expect_periods(8, 0, "R8 hs stopped");

    // R9: card stop only
    reg_write(32'h105);
    expect_periods(0, 4, "R9 card stopped");

    // R10: both stops, fields kept
    reg_write(32'h305);
    chk(rd_data == 32'h305, "R10 readback fields kept", int'(rd_data), 32'h305);
    expect_periods(0, 0, "R10 both stopped");

    // R2: bits outside the fields are dropped
    reg_write(32'hFFFF_FCE1);
    chk(rd_data == 32'h001, "R2 readback mask", int'(rd_data), 32'h001);
    expect_periods(4, 2, "R2 R3 p0f1");

    // R7: ratio change mid period, pulses are 4 or 1 cycles long
    reg_write(32'h005);
    expect_periods(8, 4, "R7 before change");
    repeat (3) @(negedge clk);
    reg_write(32'h000);
    first   = 1'b1;
    prev    = card_clk;
    run_len = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (card_clk == prev) begin
        run_len++;
      end else begin
        if (!first)
          chk(run_len + 1 == 4 || run_len + 1 == 1, "R7 pulse length", run_len + 1, 4);
        first   = 1'b0;
        run_len = 0;
        prev    = card_clk;
      end
    end
    expect_periods(2, 2, "R7 after change");

    // R6: flag still set after valid writes
    chk(err == 1'b1, "R6 err sticky", int'(err), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule